// File: doc/BRIEF.md
# Sequential Prefetch Trigger for a Two-Line Cache

This block sits beside a small two-line cache whose lines each hold eight bytes. It watches every processor access and decides whether the access should start a predictive fill of the next sequential line. When it decides to prefetch, it also names which of the two lines the new data should replace. The fill and flush data movement itself belongs to other logic. That logic reports a completed refill back on the `fill_done_i` and `fill_line_i` inputs.

An eight-bit mask selects the byte offsets inside a line that may start a prefetch. Normally only accesses flagged as streaming may start one. A force bit lets any access start one. Each line starts at most one prefetch per refill.

In ping-pong mode, a long sequential stream is kept inside two alternating lines. The line chosen for replacement is always the one the stream is not using. Without ping-pong, the replaced line is the one the triggering access did not touch, which is the least recently used of the two.

Top module: `pf_trigger`

## Requirements
- R1: A qualifying access at byte offset k starts a prefetch only if mask bit (7 − k) is 1. For example, mask 0xFF covers offsets 0..7, mask 0x3F covers offsets 2..7, and mask 0x03 covers offsets 6..7.
- R2: With the mask at 0x00, no access ever raises `pf_req_o`.
- R3: An access with `acc_stream_i` low never starts a prefetch unless `cfg_force_i` is 1.
- R4: After reset both lines are armed. When a line starts a prefetch it becomes disarmed, and later accesses to it start nothing.
- R5: A pulse on `fill_done_i` re-arms the line named by `fill_line_i`. When that refill and a trigger on the same line fall in the same cycle, the line stays armed.
- R6: With `cfg_pingpong_i` at 1, `pf_victim_o` is the opposite of the line of the most recent streaming access. The triggering access counts when it is itself streaming.
- R7: With `cfg_pingpong_i` at 0, `pf_victim_o` is the opposite of the line the triggering access touched.
- R8: `pf_req_o` is registered and high for exactly the one cycle after a triggering access. It is low after reset, with `pf_victim_o` at 0.
- R9: While `acc_valid_i` is low, the block raises no request and changes neither the armed state nor the stream line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | A processor access is present this cycle |
| acc_offset_i | input | 3 | Byte offset of the access within its line |
| acc_stream_i | input | 1 | The access belongs to a sequential stream |
| acc_line_i | input | 1 | Index of the line the access hits |
| fill_done_i | input | 1 | A line refill completed this cycle |
| fill_line_i | input | 1 | Index of the refilled line |
| cfg_mask_i | input | 8 | Per-offset trigger mask; bit k enables offset 7 − k |
| cfg_force_i | input | 1 | Allow non-streaming accesses to trigger |
| cfg_pingpong_i | input | 1 | Confine streams to two alternating lines |
| pf_req_o | output | 1 | Predictive fill request, one-cycle pulse |
| pf_victim_o | output | 1 | Line to be replaced by the prefetch |

## Verification
Some properties are checked by assertions on every cycle. A zero mask or an unforced non-streaming access never yields a request. A trigger disarms its line unless a refill lands on that line at once. The victim is never the line the triggering access used when that line carries the stream, or when ping-pong is off. Other behaviour only shows up in the bench's scenarios, which follow armed state across many accesses and refills: the exact mapping from offset to mask bit, the one-shot behaviour per refill, and the ping-pong victim for a forced non-streaming access that falls on the stream's own line.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int LINE_BYTES = 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  typedef logic [OFF_W-1:0] off_t;
endpackage

// File: rtl/pf_offset_match.sv
module pf_offset_match #(
  parameter int LINE_BYTES = pf_pkg::LINE_BYTES,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic [LINE_BYTES-1:0] mask_i,
  input  logic [OFF_W-1:0]      offset_i,
  output logic                  hit_o
);
  logic [LINE_BYTES-1:0] by_offset;

  // Mask is ordered with its most significant bit at offset zero.
  for (genvar k = 0; k < LINE_BYTES; k++) begin : g_map
    assign by_offset[k] = mask_i[LINE_BYTES-1-k];
  end

  assign hit_o = by_offset[offset_i];
endmodule

// File: rtl/pf_arm_track.sv
module pf_arm_track #(
  parameter int NUM_LINES = 2,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [IDX_W-1:0] trig_line_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_line_i,
  output logic [NUM_LINES-1:0] armed_o
);
  logic [NUM_LINES-1:0] armed_q, armed_d;
  logic                 armed_en;

  assign armed_en = trig_i | fill_i;

  always_comb begin
    armed_d = armed_q;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (trig_i && trig_line_i == IDX_W'(i)) armed_d[i] = 1'b0;
      if (fill_i && fill_line_i == IDX_W'(i)) armed_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= '1;
    else if (armed_en) armed_q <= armed_d;
  end

  assign armed_o = armed_q;

  // R4
  disarm_on_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !(fill_i && fill_line_i == trig_line_i)) |=> !armed_q[$past(trig_line_i)]);

  // R5
  rearm_on_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_i |=> armed_q[$past(fill_line_i)]);
endmodule

// File: rtl/pf_victim_sel.sv
module pf_victim_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid_i,
  input  logic acc_stream_i,
  input  logic acc_line_i,
  input  logic pingpong_i,
  output logic victim_o
);
  logic stream_q, stream_d, stream_en;
  logic cur_stream;

  assign stream_en  = acc_valid_i & acc_stream_i;
  assign stream_d   = acc_line_i;
  assign cur_stream = stream_en ? acc_line_i : stream_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stream_q <= 1'b0;
    else if (stream_en) stream_q <= stream_d;
  end

  always_comb begin
    if (pingpong_i) victim_o = ~cur_stream;
    else            victim_o = ~acc_line_i;
  end

  // R9
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |=> $stable(stream_q));
endmodule

// File: rtl/pf_trigger.sv
module pf_trigger #(
  parameter int LINE_BYTES = pf_pkg::LINE_BYTES,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid_i,
  input  logic [OFF_W-1:0]      acc_offset_i,
  input  logic                  acc_stream_i,
  input  logic                  acc_line_i,
  input  logic                  fill_done_i,
  input  logic                  fill_line_i,
  input  logic [LINE_BYTES-1:0] cfg_mask_i,
  input  logic                  cfg_force_i,
  input  logic                  cfg_pingpong_i,
  output logic                  pf_req_o,
  output logic                  pf_victim_o
);
  localparam int NUM_LINES = 2;

  logic                 off_hit, qualify, trig;
  logic [NUM_LINES-1:0] armed;
  logic                 victim_d;
  logic                 req_q, req_d;
  logic                 vic_q, vic_d;

  pf_offset_match #(.LINE_BYTES(LINE_BYTES)) u_match (
    .mask_i   (cfg_mask_i),
    .offset_i (acc_offset_i),
    .hit_o    (off_hit)
  );

  pf_arm_track #(.NUM_LINES(NUM_LINES)) u_arm (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig),
    .trig_line_i (acc_line_i),
    .fill_i      (fill_done_i),
    .fill_line_i (fill_line_i),
    .armed_o     (armed)
  );

  pf_victim_sel u_vic (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid_i  (acc_valid_i),
    .acc_stream_i (acc_stream_i),
    .acc_line_i   (acc_line_i),
    .pingpong_i   (cfg_pingpong_i),
    .victim_o     (victim_d)
  );

  assign qualify = acc_valid_i & (acc_stream_i | cfg_force_i);
  assign trig    = qualify & off_hit & armed[acc_line_i];

  always_comb begin
    req_d = trig;
    vic_d = trig ? victim_d : vic_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vic_q <= 1'b0;
    end else begin
      req_q <= req_d;
      if (trig) vic_q <= vic_d;
    end
  end

  assign pf_req_o    = req_q;
  assign pf_victim_o = vic_q;

  // R2
  zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && cfg_mask_i == '0) |=> !pf_req_o);

  // R3
  nonstream_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !acc_stream_i && !cfg_force_i) |=> !pf_req_o);

  // R8
  req_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |=> !pf_req_o);

  // R6
  pp_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_stream_i && cfg_pingpong_i && trig) |=> pf_victim_o != $past(acc_line_i));

  // R7
  lru_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !cfg_pingpong_i && trig) |=> pf_victim_o != $past(acc_line_i));
endmodule

// File: tb/pf_trigger_tb.sv
module pf_trigger_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_valid, acc_stream, acc_line, fill_done, fill_line;
  logic [2:0] acc_offset;
  logic [7:0] cfg_mask;
  logic       cfg_force, cfg_pingpong;
  logic       pf_req, pf_victim;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  bit       m_arm [2];
  bit       m_sline;

  always #2 clk = ~clk;

  pf_trigger u_dut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid_i(acc_valid), .acc_offset_i(acc_offset), .acc_stream_i(acc_stream),
    .acc_line_i(acc_line), .fill_done_i(fill_done), .fill_line_i(fill_line),
    .cfg_mask_i(cfg_mask), .cfg_force_i(cfg_force), .cfg_pingpong_i(cfg_pingpong),
    .pf_req_o(pf_req), .pf_victim_o(pf_victim)
  );

  function automatic bit exp_trig(bit v, bit [2:0] off, bit s, bit ln);
    return v && (s || cfg_force) && cfg_mask[7-off] && m_arm[ln];
  endfunction

  function automatic bit exp_victim(bit v, bit s, bit ln);
    if (cfg_pingpong) return !((v && s) ? ln : m_sline);
    return !ln;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(string req, bit v, bit [2:0] off, bit s, bit ln,
                      bit fd = 0, bit fl = 0);
    bit t, vic;
    @(negedge clk);
    acc_valid = v; acc_offset = off; acc_stream = s; acc_line = ln;
    fill_done = fd; fill_line = fl;
    t   = exp_trig(v, off, s, ln);
    vic = exp_victim(v, s, ln);
    if (t) m_arm[ln] = 0;
    if (fd) m_arm[fl] = 1;
    if (v && s) m_sline = ln;
    @(posedge clk); #1;
    check(req, pf_req, t);
    if (t) check({req, " victim"}, pf_victim, vic);
    acc_valid = 0; fill_done = 0;
  endtask

  task automatic refill_both();
    step("R5", 0, 0, 0, 0, 1, 0);
    step("R5", 0, 0, 0, 0, 1, 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 0; acc_valid = 0; acc_offset = 0; acc_stream = 0; acc_line = 0;
    fill_done = 0; fill_line = 0; cfg_mask = 8'hFF; cfg_force = 0; cfg_pingpong = 0;
    m_arm[0] = 1; m_arm[1] = 1; m_sline = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset req", pf_req, 0);
    check("R8 reset victim", pf_victim, 0);
    @(negedge clk); rst_n = 1;

    // R1 full offset sweep per mask
    foreach (cfg_mask[b]) begin end
    for (int mi = 0; mi < 3; mi++) begin
      cfg_mask = (mi == 0) ? 8'hFF : (mi == 1) ? 8'h3F : 8'h03;
      for (int o = 0; o < 8; o++) begin
        refill_both();
        step("R1", 1, 3'(o), 1, 0);
      end
    end

    // R2 zero mask
    cfg_mask = 8'h00; refill_both();
    for (int o = 0; o < 8; o++) step("R2", 1, 3'(o), 1, o[0]);

    // R3 non-stream with and without force
    cfg_mask = 8'hFF; refill_both();
    step("R3 unforced", 1, 3, 0, 1);
    cfg_force = 1;
    step("R3 forced", 1, 3, 0, 1);
    cfg_force = 0;

    // R4 one-shot, R5 rearm and simultaneous
    refill_both();
    step("R4 first", 1, 0, 1, 0);
    step("R4 again", 1, 5, 1, 0);
    step("R5 refill", 0, 0, 0, 0, 1, 0);
    step("R5 after refill", 1, 1, 1, 0);
    step("R5 same cycle", 1, 2, 1, 1, 1, 1);
    step("R5 still armed", 1, 4, 1, 1);

    // R9 idle access with junk fields
    refill_both();
    step("R9", 0, 7, 1, 1);
    step("R9 arm kept", 1, 7, 1, 1);

    // R6 ping-pong with forced non-stream on stream line
    cfg_pingpong = 1; cfg_force = 1; refill_both();
    step("R6 stream", 1, 0, 1, 1);
    step("R6 forced", 1, 0, 0, 0);
    refill_both();
    step("R6 forced same", 1, 0, 0, 1);
    cfg_pingpong = 0;
    refill_both();
    step("R7", 1, 0, 0, 1);
    cfg_force = 0;

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        cfg_mask     = 8'($urandom);
        cfg_force    = 1'($urandom);
        cfg_pingpong = 1'($urandom);
      end
      step("R1 R6 R7 random", 1'($urandom_range(0, 3) != 0), 3'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule